// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the descriptor engine on the transmit side of an Ethernet MAC. Software places two-word buffer descriptors in a circular list in memory, gives each one to the hardware by clearing its ownership bit, programs the list base, and writes a start bit. The engine then reads descriptors one after another. It fetches the data of each owned buffer word by word over a simple memory request/response port and hands it, one byte per transfer, to the framer over a valid/ready stream. After the framer accepts the last byte of a buffer, the engine writes the ownership bit back to 1.

The engine keeps an internal pointer into the list. It moves the pointer one entry forward, or back to the base when the descriptor carries a wrap mark. It returns the pointer to the programmed base without notice in two cases: when it meets a descriptor that software still holds, and after any transmit error. A walk that ends normally therefore always finishes with a used-bit-read indication. Software must restart from the base after every stop.

Stream rules: `tx_valid` rises only while a buffer is being sent. Once raised, `tx_valid`, `tx_data` and `tx_last` hold their values until `tx_ready` is seen high at a clock edge. The only exception is an abort caused by an error. A stalled `tx_ready` simply stalls the walk. The memory request side follows the same hold rule. At most one read is outstanding, and a read response is taken in whatever cycle it arrives.

Top module: `tx_desc_ring`

## Requirements
- R1: A descriptor is two 32-bit words at pointer P. The word at P is the buffer byte address, which must be word aligned. The word at P+4 holds: bit 31 ownership (1 = used), bit 30 wrap, bit 15 end-of-frame, bits 10:0 length in bytes. Both words are read, the one at P first, before any buffer data is requested.
- R2: For a descriptor with bit 31 = 0, exactly `length` bytes are streamed, little-endian within each fetched word. `tx_last` is 1 only on the final byte of a descriptor that has end-of-frame set.
- R3: Once `tx_valid` or `mem_req_valid` is raised, it and its payload hold until the matching ready is high at a clock edge. The only exception is an error abort.
- R4: After the last byte of a buffer is accepted, word 1 of that descriptor is written back with bit 31 set and all other bits unchanged. A zero-length descriptor is written back without streaming any byte.
- R5: After a write-back, the pointer moves forward by 8, or returns to the base if the wrap bit is set. The next descriptor is then read, including after an end-of-frame descriptor.
- R6: If a descriptor read at the start of a frame has bit 31 = 1, status bit 0 (used-bit-read) sets, the pointer returns to the base and the engine stops (go = 0).
- R7: If such a used descriptor is met in the middle of a frame, status bit 2 (buffer exhausted) sets instead of bit 0, the pointer returns to the base and the engine stops.
- R8: A pulse on `err_retry_limit` sets status bit 1, and a pulse on `err_underrun` sets status bit 3. Either one stops the walk at the next request or send cycle, returns the pointer to the base and leaves the current descriptor unwritten. A later start resumes from the base.
- R9: Register 0 bit 0 written as 1 starts the walk from the current pointer. Status bit 5 (register 3) reads 1 while the walk is active. Register 2 reads the pointer, which is 0 after reset.
- R10: A write to register 1 sets the base to the written value with bits 2:0 cleared, and also loads the pointer. The write is ignored while go = 1.
- R11: Status bit 4 sets when the write-back of an end-of-frame descriptor is accepted. Status bits 4:0 are cleared by writing 1 to them in register 3.
- R12: Register 5 records the same five events and is cleared by reading it. Register 4 enables them bit by bit, and `irq` is the OR of the pending bits that are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects happen at the edge) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Byte valid toward the framer |
| tx_ready | input | 1 | Framer accepts the byte |
| tx_data | output | 8 | Byte to send |
| tx_last | output | 1 | Final byte of a frame |
| err_retry_limit | input | 1 | Retry-limit error pulse from the framer |
| err_underrun | input | 1 | Underrun error pulse from the framer |

## Verification
A wrong pointer shows up within one descriptor. Bytes arrive from the wrong buffer, or the stream is too long or too short, or a slot is written back out of turn, or the pointer register reads something other than the base once go falls. A wrong ownership decision shows as the wrong one of the used-bit-read and buffer-exhausted status bits, or as a missing completion bit, as soon as the walk stops. Errors injected while the framer stalls the stream must stop the stream within two cycles and leave the descriptor in memory unwritten.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int NEV    = 5;
  localparam int ST_UBR = 0;
  localparam int ST_RLE = 1;
  localparam int ST_BEX = 2;
  localparam int ST_UND = 3;
  localparam int ST_CMP = 4;
  localparam int ST_GO  = 5;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_BASE  = 3'd1;
  localparam logic [2:0] RA_PTR   = 3'd2;
  localparam logic [2:0] RA_STAT  = 3'd3;
  localparam logic [2:0] RA_IEN   = 3'd4;
  localparam logic [2:0] RA_ISTAT = 3'd5;

  localparam int DW_USED = 31;
  localparam int DW_WRAP = 30;
  localparam int DW_EOF  = 15;

  typedef enum logic [3:0] {
    W_IDLE, W_RD0, W_WT0, W_RD1, W_WT1, W_DREQ, W_DWT, W_SEND, W_WB
  } wstate_t;
endpackage

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           go,
  input  logic [AW-1:0]  ptr,
  input  logic [NEV-1:0] ev,
  output logic           start,
  output logic           base_wr,
  output logic [AW-1:0]  base_din,
  output logic [AW-1:0]  base_q,
  output logic           irq
);
  logic [NEV-1:0] sts, ien, ist;
  logic           sts_w1c, ist_rd;

  always_comb begin
    start    = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && !go;
    base_wr  = reg_wr && (reg_addr == RA_BASE);
    base_din = AW'(reg_wdata) & ~AW'(7);
    sts_w1c  = reg_wr && (reg_addr == RA_STAT);
    ist_rd   = reg_rd && (reg_addr == RA_ISTAT);
    irq      = |(ist & ien);
    case (reg_addr)
      RA_PTR:   reg_rdata = 32'(ptr);
      RA_STAT:  reg_rdata = 32'({go, sts});
      RA_IEN:   reg_rdata = 32'(ien);
      RA_ISTAT: reg_rdata = 32'(ist);
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sts    <= '0;
      ien    <= '0;
      ist    <= '0;
    end else begin
      if (base_wr && !go) base_q <= base_din;
      if (reg_wr && reg_addr == RA_IEN) ien <= reg_wdata[NEV-1:0];
      sts <= (sts & ~(sts_w1c ? reg_wdata[NEV-1:0] : '0)) | ev;
      ist <= (ist_rd ? '0 : ist) | ev;
    end
  end

  // R10: a base write during an active walk leaves the base untouched
  assert_base_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr && go |=> $stable(base_q));
  // R12: reading pending interrupts with no new event drops the request
  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ist_rd && (ev == '0) |=> !irq);
endmodule

// File: rtl/txring_walk.sv
module txring_walk
  import txring_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          base_wr,
  input  logic [AW-1:0] base_din,
  input  logic [AW-1:0] base_q,
  input  logic          err_rle,
  input  logic          err_und,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_we,
  output logic [AW-1:0] mreq_addr,
  output logic [31:0]   mreq_wdata,
  input  logic          mrsp_valid,
  input  logic [31:0]   mrsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          busy,
  output logic [AW-1:0] ptr,
  output logic          ev_ubr,
  output logic          ev_bex,
  output logic          ev_cmp
);
  localparam logic [AW-1:0] STEP = AW'(8);
  localparam logic [AW-1:0] W1OFS = AW'(4);

  wstate_t       st;
  logic [AW-1:0] buf_addr;
  logic [31:0]   w1, dword;
  logic [LW-1:0] sent, len;
  logic          midframe, abort_pend;
  logic          is_req, abort_now, last_byte, mhs, hs, err_any;

  always_comb begin
    err_any    = err_rle || err_und;
    len        = w1[LW-1:0];
    is_req     = (st == W_RD0) || (st == W_RD1) || (st == W_DREQ) || (st == W_WB);
    abort_now  = abort_pend && (is_req || st == W_SEND);
    busy       = (st != W_IDLE);
    mreq_valid = is_req && !abort_now;
    mreq_we    = (st == W_WB);
    case (st)
      W_RD1, W_WB: mreq_addr = ptr + W1OFS;
      W_DREQ:      mreq_addr = buf_addr + AW'({sent[LW-1:2], 2'b00});
      default:     mreq_addr = ptr;
    endcase
    mreq_wdata = w1 | (32'h1 << DW_USED);
    tx_valid   = (st == W_SEND) && !abort_now;
    tx_data    = dword[{sent[1:0], 3'b000} +: 8];
    last_byte  = (sent + LW'(1)) == len;
    tx_last    = w1[DW_EOF] && last_byte;
    mhs        = mreq_valid && mreq_ready;
    hs         = tx_valid && tx_ready;
    ev_ubr     = (st == W_WT1) && mrsp_valid && mrsp_data[DW_USED] && !midframe;
    ev_bex     = (st == W_WT1) && mrsp_valid && mrsp_data[DW_USED] && midframe;
    ev_cmp     = (st == W_WB) && mhs && w1[DW_EOF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      ptr        <= '0;
      buf_addr   <= '0;
      w1         <= '0;
      dword      <= '0;
      sent       <= '0;
      midframe   <= 1'b0;
      abort_pend <= 1'b0;
    end else begin
      if (err_any && busy) abort_pend <= 1'b1;
      if (abort_now) begin
        st         <= W_IDLE;
        ptr        <= base_q;
        abort_pend <= 1'b0;
        midframe   <= 1'b0;
      end else begin
        case (st)
          W_IDLE: begin
            abort_pend <= 1'b0;
            if (err_any) ptr <= base_q;
            else if (base_wr) ptr <= base_din;
            if (start) begin
              st       <= W_RD0;
              midframe <= 1'b0;
            end
          end
          W_RD0: if (mhs) st <= W_WT0;
          W_WT0: if (mrsp_valid) begin
            buf_addr <= AW'(mrsp_data);
            st       <= W_RD1;
          end
          W_RD1: if (mhs) st <= W_WT1;
          W_WT1: if (mrsp_valid) begin
            w1   <= mrsp_data;
            sent <= '0;
            if (mrsp_data[DW_USED]) begin
              st       <= W_IDLE;
              ptr      <= base_q;
              midframe <= 1'b0;
            end else if (mrsp_data[LW-1:0] == '0) st <= W_WB;
            else st <= W_DREQ;
          end
          W_DREQ: if (mhs) st <= W_DWT;
          W_DWT: if (mrsp_valid) begin
            dword <= mrsp_data;
            st    <= W_SEND;
          end
          W_SEND: if (hs) begin
            sent <= sent + LW'(1);
            if (last_byte) st <= W_WB;
            else if (sent[1:0] == 2'd3) st <= W_DREQ;
          end
          W_WB: if (mhs) begin
            ptr      <= w1[DW_WRAP] ? base_q : ptr + STEP;
            midframe <= !w1[DW_EOF];
            st       <= W_RD0;
          end
          default: st <= W_IDLE;
        endcase
      end
    end
  end

  // R3: stream payload holds under back-pressure unless an error aborts
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !abort_pend && !err_any
    |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R3: memory request holds until accepted unless an error aborts
  assert_mreq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready && !abort_pend && !err_any
    |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_we));
  // R4: every write toward memory returns ownership to software
  assert_wb_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_we |-> mreq_wdata[DW_USED]);
  // R6: a used descriptor at frame start stops the walk at the base
  assert_ubr_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ubr |=> !busy && (ptr == base_q));
  // R8: an error stops the stream within two cycles
  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_any && tx_valid |=> ##1 !tx_valid);
  // R9: nothing moves while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !mreq_valid);
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import txring_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          err_retry_limit,
  input  logic          err_underrun
);
  logic           start, base_wr, busy, ev_ubr, ev_bex, ev_cmp;
  logic [AW-1:0]  base_din, base_q, ptr;
  logic [NEV-1:0] ev;

  always_comb begin
    ev         = '0;
    ev[ST_UBR] = ev_ubr;
    ev[ST_RLE] = err_retry_limit;
    ev[ST_BEX] = ev_bex;
    ev[ST_UND] = err_underrun;
    ev[ST_CMP] = ev_cmp;
  end

  txring_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .go(busy), .ptr(ptr), .ev(ev), .start(start), .base_wr(base_wr),
    .base_din(base_din), .base_q(base_q), .irq(irq)
  );

  txring_walk #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .base_wr(base_wr),
    .base_din(base_din), .base_q(base_q),
    .err_rle(err_retry_limit), .err_und(err_underrun),
    .mreq_valid(mem_req_valid), .mreq_ready(mem_req_ready),
    .mreq_we(mem_req_we), .mreq_addr(mem_req_addr), .mreq_wdata(mem_req_wdata),
    .mrsp_valid(mem_rsp_valid), .mrsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .busy(busy), .ptr(ptr), .ev_ubr(ev_ubr), .ev_bex(ev_bex), .ev_cmp(ev_cmp)
  );
endmodule

// File: tb/sim_tx_desc_ring.sv
module sim_tx_desc_ring;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq;
  logic        mem_req_valid, mem_req_ready = 1, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        tx_valid, tx_ready = 1, tx_last;
  logic [7:0]  tx_data;
  logic        err_retry_limit = 0, err_underrun = 0;

  tx_desc_ring u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .err_retry_limit(err_retry_limit), .err_underrun(err_underrun)
  );

  int vectors = 0, fails = 0, cyc = 0;
  logic stall = 0, hold_tx = 0;
  logic [31:0] mem [0:255];
  logic [7:0]  cap_d [0:1023];
  logic        cap_l [0:1023];
  int          cap_n = 0;
  int          sd_addr [0:7];
  int          sd_len  [0:7];
  logic [31:0] sd_w1   [0:7];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tx_ready      <= hold_tx ? 1'b0 : (stall ? (cyc % 3 == 1) : 1'b1);
    mem_req_ready <= stall ? (cyc % 2 == 0) : 1'b1;
  end
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[9:2]] = mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
      end
    end
  end
  always @(posedge clk) if (tx_valid && tx_ready) begin
    cap_d[cap_n % 1024] <= tx_data;
    cap_l[cap_n % 1024] <= tx_last;
    cap_n <= cap_n + 1;
  end

  function automatic logic [7:0] mb(input int b);
    return 8'((b * 7 + 1) & 255);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  // R1 layout: word1 = {used, wrap, 14'b0, eof, 4'b0, len[10:0]}
  task automatic put(input int s, input int len, input bit eof, input bit wrap, input bit used);
    sd_addr[s] = 32'h200 + s * 16;
    sd_len[s]  = len;
    sd_w1[s]   = {used, wrap, 14'd0, eof, 4'd0, 11'(len)};
    mem[(BASE >> 2) + 2 * s]     = sd_addr[s];
    mem[(BASE >> 2) + 2 * s + 1] = sd_w1[s];
  endtask

  task automatic prep();
    for (int w = 0; w < 256; w++)
      mem[w] = {mb(4*w+3), mb(4*w+2), mb(4*w+1), mb(4*w)};
    for (int s = 0; s < 8; s++) put(s, 0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic launch(output int cap0);
    logic [31:0] d;
    wr(3'd1, BASE);
    rd(3'd5, d);
    wr(3'd3, 32'h1f);
    cap0 = cap_n;
    wr(3'd0, 32'h1);
  endtask

  task automatic wait_stop();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, d);
      if (!d[5]) break;
    end
  endtask

  task automatic verify(input string tag, input int cap0, input int nx);
    int pos = 0, bad = 0, badl = 0, badw = 0;
    for (int s = 0; s < nx; s++) begin
      for (int j = 0; j < sd_len[s]; j++) begin
        if (cap_d[(cap0 + pos) % 1024] !== mb(sd_addr[s] + j)) bad++;
        if (cap_l[(cap0 + pos) % 1024] !== (sd_w1[s][15] && j == sd_len[s] - 1)) badl++;
        pos++;
      end
      if (mem[(BASE >> 2) + 2 * s + 1] !== (sd_w1[s] | 32'h8000_0000)) badw++;
    end
    chk({tag, " R2 byte count"}, cap_n - cap0, pos);
    chk({tag, " R2 byte values"}, bad, 0);
    chk({tag, " R2 last flags"}, badl, 0);
    chk({tag, " R4 write-back"}, badw, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0;
    prep();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(3'd2, d); chk("R9 reset pointer", d, 0);
    rd(3'd3, d); chk("R11 reset status", d, 0);
    chk("R12 reset irq", irq, 0);
    chk("R9 reset stream idle", tx_valid, 0);

    // sweep single frames, lengths 1..9, with and without back-pressure
    for (int st = 0; st < 2; st++) begin
      for (int len = 1; len <= 9; len++) begin
        stall = st[0];
        prep(); put(0, len, 1'b1, 1'b0, 1'b0);
        launch(c0); wait_stop();
        verify($sformatf("single len=%0d stall=%0d", len, st), c0, 1);
        rd(3'd3, d); chk("R6 R11 status after frame", d, 32'h11);
        rd(3'd2, d); chk("R6 pointer back at base", d, BASE);
        chk("R12 irq masked", irq, 0);
      end
    end
    stall = 0;

    // multi-buffer frames, zero-length buffer included (R4)
    prep();
    put(0, 3, 1'b0, 1'b0, 1'b0); put(1, 5, 1'b1, 1'b0, 1'b0);
    put(2, 0, 1'b0, 1'b0, 1'b0); put(3, 7, 1'b0, 1'b0, 1'b0); put(4, 2, 1'b1, 1'b0, 1'b0);
    launch(c0); wait_stop();
    verify("multi R5", c0, 5);
    rd(3'd3, d); chk("R5 R6 status after ring", d, 32'h11);

    // wrap: slot 2 wraps, free slot 3 must be skipped
    prep();
    put(0, 2, 1'b1, 1'b0, 1'b0); put(1, 3, 1'b1, 1'b0, 1'b0);
    put(2, 4, 1'b1, 1'b1, 1'b0); put(3, 5, 1'b1, 1'b0, 1'b0);
    launch(c0); wait_stop();
    verify("wrap R5", c0, 3);
    chk("R5 slot after wrap untouched", mem[(BASE >> 2) + 7], sd_w1[3]);
    rd(3'd2, d); chk("R5 pointer at base", d, BASE);

    // buffer exhausted mid-frame
    prep(); put(0, 4, 1'b0, 1'b0, 1'b0);
    launch(c0); wait_stop();
    verify("midframe R7", c0, 1);
    rd(3'd3, d); chk("R7 exhausted flag only", d, 32'h04);
    rd(3'd2, d); chk("R7 pointer at base", d, BASE);

    // retry-limit error while stalled, base write ignored (R10)
    prep(); put(0, 12, 1'b1, 1'b0, 1'b0);
    hold_tx = 1;
    launch(c0);
    for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
    wr(3'd1, 32'h80);
    @(negedge clk); err_retry_limit = 1;
    @(negedge clk); err_retry_limit = 0;
    repeat (2) @(negedge clk);
    chk("R8 stream stopped", tx_valid, 0);
    rd(3'd3, d); chk("R8 retry flag, go low", d, 32'h02);
    rd(3'd2, d); chk("R8 R10 pointer at old base", d, BASE);
    chk("R8 descriptor not written", mem[(BASE >> 2) + 1][31], 0);
    hold_tx = 0;

    // underrun error while stalled
    prep(); put(0, 10, 1'b1, 1'b0, 1'b0);
    hold_tx = 1;
    launch(c0);
    for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
    @(negedge clk); err_underrun = 1;
    @(negedge clk); err_underrun = 0;
    repeat (2) @(negedge clk);
    hold_tx = 0;
    rd(3'd3, d); chk("R8 underrun flag, go low", d, 32'h08);
    rd(3'd2, d); chk("R8 pointer at base after underrun", d, BASE);
    // restart after error resumes from base
    prep(); put(0, 6, 1'b1, 1'b0, 1'b0);
    launch(c0); wait_stop();
    verify("restart R8", c0, 1);

    // interrupts and write-1-to-clear
    prep(); put(0, 2, 1'b1, 1'b0, 1'b0);
    wr(3'd4, 32'h10);
    launch(c0); wait_stop();
    chk("R12 irq on completion", irq, 1);
    rd(3'd5, d); chk("R12 pending events", d, 32'h11);
    chk("R12 irq cleared by read", irq, 0);
    rd(3'd5, d); chk("R12 pending empty", d, 0);
    wr(3'd3, 32'h01);
    rd(3'd3, d); chk("R11 partial clear", d, 32'h10);
    wr(3'd3, 32'h10);
    rd(3'd3, d); chk("R11 full clear", d, 0);

    summary();
    $finish;
  end
endmodule